// File: doc/BRIEF.md
# Idle-State Sequencer for a Small Processor

This block moves a small processor into a low-power idle state and back out again. Software sets a request bit by writing the control register. The block then drops the clock enables of the CPU core and of the watchdog timer. The peripheral clock enable stays high throughout, so timers and serial units keep running and can produce the event that ends the idle period. Memory, core registers and port latches are not touched. The core is frozen with its program counter already pointing past the write that started idle.

Three run modes exist: two full-speed modes and a slow mode. Each has an idle counterpart, and the idle counterpart is picked from the run mode in force when the request is written. The idle state ends when any interrupt latch whose enable is set goes high, or when the dedicated external interrupt 0 input goes high. On that event the block returns to the run mode it came from.

The master interrupt enable selects what happens next. With the enable clear, the core simply resumes after the entry write, and software must clear the waking latch itself. With the enable set, the block also pulses an interrupt-dispatch request to the vectoring logic. A watchdog interrupt that is already pending when idle is requested cancels the request. An active-low reset ends idle at once and leaves the block in the second full-speed mode.

Top module: `idle_ctrl`

## Requirements
- R1: After reset the block is in run mode NORMAL2, coded 3'b001. Both the CPU and watchdog clock enables are 1, and the idle request and dispatch outputs are 0.
- R2: A write with data bit 4 set moves the block into idle at the clock edge of the write. This applies only in a run mode and only with no watchdog interrupt pending. From the next cycle the idle request reads 1 and both the CPU and watchdog clock enables read 0, while the peripheral clock enable stays 1.
- R3: Mode codes are NORMAL1 3'b000, NORMAL2 3'b001, SLOW 3'b010, IDLE1 3'b100, IDLE2 3'b101 and SLEEP 3'b110. Entry sets bit 2 of the current run mode, giving NORMAL1 to IDLE1, NORMAL2 to IDLE2 and SLOW to SLEEP. Wake clears bit 2 again, restoring the same run mode.
- R4: While idle, the block leaves idle at the next clock edge if any bit of the latch input is 1 and the same bit of the enable input is also 1, or if external interrupt 0 is 1. At that edge the idle request clears. A latch bit whose enable bit is 0 does not wake the block.
- R5: The CPU and watchdog clock enables return to 1 one cycle after the idle request clears.
- R6: A wake with the master interrupt enable at 1 raises the dispatch output for exactly one cycle, the cycle after the wake edge. A wake with the master enable at 0 raises no dispatch.
- R7: A write with bit 4 set while the watchdog interrupt input is 1 does not enter idle. The mode and the idle request stay unchanged.
- R8: A write with bit 4 clear selects a run mode from data bits 1:0 (00 NORMAL1, 01 NORMAL2, 10 SLOW). The value 11 leaves the mode unchanged.
- R9: Register writes made while idle have no effect on the mode.
- R10: Driving the reset input low during idle forces NORMAL2 and clears the idle request at once, without waiting for a clock edge.
- R11: A wake condition already present when idle is entered ends idle at the very next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | CTRL_W | Write data: bit 4 idle request, bits 1:0 run-mode select |
| irq_latch_i | input | NUM_IRQ | Interrupt latch states |
| irq_en_i | input | NUM_IRQ | Individual interrupt enables |
| ext_int0_i | input | 1 | External interrupt 0 request |
| ime_i | input | 1 | Master interrupt enable |
| wdt_irq_i | input | 1 | Watchdog interrupt pending |
| mode_o | output | 3 | Current operating mode |
| idle_req_o | output | 1 | Idle request bit |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| int_dispatch_o | output | 1 | Interrupt-dispatch request pulse |

## Verification
The enter/wake round trip is run from each of the three run modes. Each mode is tried with an enabled latch and with external interrupt 0 as the waking source, and with the master enable both set and clear. This separates a wrong idle-variant mapping from a wrong return mode, and a missing wake path from a dispatch that ignores the master enable. Directed cases then apply the patterns that should do nothing: a latch whose enable is clear, a write while idle, the unused run-mode code, and an entry request with the watchdog interrupt pending. They also cover a wake source that is already live at entry and reset asserted in the middle of idle.

// File: rtl/idle_ctrl_pkg.sv
package idle_ctrl_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL1 = 3'b000,
    MODE_NORMAL2 = 3'b001,
    MODE_SLOW    = 3'b010,
    MODE_IDLE1   = 3'b100,
    MODE_IDLE2   = 3'b101,
    MODE_SLEEP   = 3'b110
  } mode_e;

  localparam int unsigned MODE_W    = 3;
  localparam int unsigned RUN_SEL_W = 2;
  localparam logic [RUN_SEL_W-1:0] RUN_SEL_BAD = 2'b11;
endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_latch_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               ext_int0_i,
  output logic               wake_src_o
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_hit
    assign hit[g] = irq_latch_i[g] & irq_en_i[g];
  end

  assign wake_src_o = (|hit) | ext_int0_i;
endmodule

// File: rtl/idle_mode_reg.sv
module idle_mode_reg
  import idle_ctrl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_idle_i,
  input  logic [RUN_SEL_W-1:0] wr_sel_i,
  input  logic                 wdt_irq_i,
  input  logic                 wake_src_i,
  output mode_e                mode_o,
  output logic                 idle_req_o,
  output logic                 enter_o,
  output logic                 wake_o
);
  mode_e mode_q;
  logic  idle_q;
  logic  wr_ok;

  // CPU is frozen while idle, so writes then are dropped
  assign wr_ok   = wr_en_i & ~idle_q;
  assign enter_o = wr_ok & wr_idle_i & ~wdt_irq_i;
  assign wake_o  = idle_q & wake_src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL2;
      idle_q <= 1'b0;
    end else if (wake_o) begin
      idle_q <= 1'b0;
      mode_q <= mode_e'({1'b0, mode_q[RUN_SEL_W-1:0]});
    end else if (enter_o) begin
      idle_q <= 1'b1;
      mode_q <= mode_e'({1'b1, mode_q[RUN_SEL_W-1:0]});
    end else if (wr_ok && !wr_idle_i && wr_sel_i != RUN_SEL_BAD) begin
      mode_q <= mode_e'({1'b0, wr_sel_i});
    end
  end

  assign mode_o     = mode_q;
  assign idle_req_o = idle_q;
endmodule

// File: rtl/idle_clk_gate.sv
module idle_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic idle_req_i,
  input  logic wake_i,
  input  logic ime_i,
  output logic cpu_clk_en_o,
  output logic wdt_clk_en_o,
  output logic dispatch_o
);
  logic gate_q;
  logic disp_q;

  // gate trails the request by one cycle on release only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      disp_q <= 1'b0;
    end else begin
      gate_q <= enter_i | idle_req_i;
      disp_q <= wake_i & ime_i;
    end
  end

  assign cpu_clk_en_o = ~gate_q;
  assign wdt_clk_en_o = ~gate_q;
  assign dispatch_o   = disp_q;
endmodule

// File: rtl/idle_ctrl.sv
module idle_ctrl
  import idle_ctrl_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 8,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned IDLE_BIT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CTRL_W-1:0]  wr_data_i,
  input  logic [NUM_IRQ-1:0] irq_latch_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               ext_int0_i,
  input  logic               ime_i,
  input  logic               wdt_irq_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic               idle_req_o,
  output logic               cpu_clk_en_o,
  output logic               wdt_clk_en_o,
  output logic               periph_clk_en_o,
  output logic               int_dispatch_o
);
  logic  wake_src;
  logic  enter;
  logic  wake;
  logic  idle_req;
  mode_e mode;
  logic  unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  idle_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_latch_i (irq_latch_i),
    .irq_en_i    (irq_en_i),
    .ext_int0_i  (ext_int0_i),
    .wake_src_o  (wake_src)
  );

  idle_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idle_i  (wr_data_i[IDLE_BIT]),
    .wr_sel_i   (wr_data_i[RUN_SEL_W-1:0]),
    .wdt_irq_i  (wdt_irq_i),
    .wake_src_i (wake_src),
    .mode_o     (mode),
    .idle_req_o (idle_req),
    .enter_o    (enter),
    .wake_o     (wake)
  );

  idle_clk_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter),
    .idle_req_i   (idle_req),
    .wake_i       (wake),
    .ime_i        (ime_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .wdt_clk_en_o (wdt_clk_en_o),
    .dispatch_o   (int_dispatch_o)
  );

  assign mode_o          = mode;
  assign idle_req_o      = idle_req;
  assign periph_clk_en_o = 1'b1;
endmodule

// File: rtl/idle_ctrl_chk.sv
module idle_ctrl_chk #(
  parameter int unsigned NUM_IRQ  = 8,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned IDLE_BIT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [CTRL_W-1:0]  wr_data_i,
  input logic [NUM_IRQ-1:0] irq_latch_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic               ext_int0_i,
  input logic               ime_i,
  input logic               wdt_irq_i,
  input logic [2:0]         mode_o,
  input logic               idle_req_o,
  input logic               cpu_clk_en_o,
  input logic               wdt_clk_en_o,
  input logic               int_dispatch_o
);
  logic unused_chk;
  assign unused_chk = ^wr_data_i;

  AST_IDLE_HALTS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_req_o |-> !cpu_clk_en_o && !wdt_clk_en_o); // R2

  AST_IDLE_FLAG_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_req_o == mode_o[2]); // R3

  AST_MODE_RESTORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_req_o) |-> !mode_o[2] && mode_o[1:0] == $past(mode_o[1:0])); // R3

  AST_WAKE_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_req_o && (|(irq_latch_i & irq_en_i) || ext_int0_i) |=> !idle_req_o); // R4

  AST_EN_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_req_o) |-> !cpu_clk_en_o ##1 (cpu_clk_en_o || idle_req_o)); // R5

  AST_DISPATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dispatch_o |=> !int_dispatch_o); // R6

  AST_DISPATCH_NEEDS_IME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dispatch_o |-> $past(ime_i) && $past(idle_req_o)); // R6

  AST_WDT_BLOCKS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_req_o && wr_en_i && wr_data_i[IDLE_BIT] && wdt_irq_i |=> !idle_req_o); // R7
endmodule

bind idle_ctrl idle_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .CTRL_W(CTRL_W), .IDLE_BIT(IDLE_BIT)
) u_chk (.*);

// File: tb/idle_ctrl_tb.sv
module idle_ctrl_tb_top;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned CTRL_W  = 8;
  localparam int NV = 6;
  // {run[1:0], ime, use_ext, exp_idle[2:0]}
  localparam logic [6:0] VECS [NV] = '{
    7'b00_0_0_100, 7'b01_1_0_101, 7'b10_0_1_110,
    7'b00_1_1_100, 7'b01_0_1_101, 7'b10_1_0_110
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [CTRL_W-1:0] wr_data_i = '0;
  logic [NUM_IRQ-1:0] irq_latch_i = '0;
  logic [NUM_IRQ-1:0] irq_en_i = '1;
  logic ext_int0_i = 1'b0;
  logic ime_i = 1'b0;
  logic wdt_irq_i = 1'b0;
  logic [2:0] mode_o;
  logic idle_req_o, cpu_clk_en_o, wdt_clk_en_o, periph_clk_en_o, int_dispatch_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idle_ctrl #(.NUM_IRQ(NUM_IRQ), .CTRL_W(CTRL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .irq_latch_i(irq_latch_i), .irq_en_i(irq_en_i), .ext_int0_i(ext_int0_i),
    .ime_i(ime_i), .wdt_irq_i(wdt_irq_i), .mode_o(mode_o),
    .idle_req_o(idle_req_o), .cpu_clk_en_o(cpu_clk_en_o),
    .wdt_clk_en_o(wdt_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .int_dispatch_o(int_dispatch_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 mode", 8'(mode_o), 8'h01);
    chk("R1 cpu_en", 8'(cpu_clk_en_o), 8'h1);
    chk("R1 wdt_en", 8'(wdt_clk_en_o), 8'h1);
    chk("R1 idle", 8'(idle_req_o), 8'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 dispatch", 8'(int_dispatch_o), 8'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] run;
      logic use_ext;
      run = VECS[i][6:5];
      ime_i = VECS[i][4];
      use_ext = VECS[i][3];
      wr({6'b0, run});
      chk("R8 run select", 8'(mode_o), 8'({1'b0, run}));
      wr(8'h10);
      chk("R2 idle set", 8'(idle_req_o), 8'h1);
      chk("R3 idle variant", 8'(mode_o), 8'(VECS[i][2:0]));
      chk("R2 cpu gated", 8'(cpu_clk_en_o), 8'h0);
      chk("R2 wdt gated", 8'(wdt_clk_en_o), 8'h0);
      chk("R2 periph on", 8'(periph_clk_en_o), 8'h1);
      @(negedge clk);
      chk("R4 stays idle", 8'(idle_req_o), 8'h1);
      if (use_ext) ext_int0_i = 1'b1;
      else irq_latch_i = 8'(1 << i);
      @(negedge clk);
      chk("R4 woken", 8'(idle_req_o), 8'h0);
      chk("R3 mode restored", 8'(mode_o), 8'({1'b0, run}));
      chk("R5 cpu still gated", 8'(cpu_clk_en_o), 8'h0);
      chk("R6 dispatch", 8'(int_dispatch_o), 8'(VECS[i][4]));
      ext_int0_i = 1'b0;
      irq_latch_i = '0;
      @(negedge clk);
      chk("R5 cpu back", 8'(cpu_clk_en_o), 8'h1);
      chk("R5 wdt back", 8'(wdt_clk_en_o), 8'h1);
      chk("R6 dispatch ends", 8'(int_dispatch_o), 8'h0);
    end

    // R8 code 11 ignored
    wr(8'h02);
    wr(8'h03);
    chk("R8 code 11", 8'(mode_o), 8'h02);

    // R7 watchdog pending cancels entry
    wdt_irq_i = 1'b1;
    wr(8'h10);
    chk("R7 no idle", 8'(idle_req_o), 8'h0);
    chk("R7 mode kept", 8'(mode_o), 8'h02);
    chk("R7 cpu runs", 8'(cpu_clk_en_o), 8'h1);
    wdt_irq_i = 1'b0;

    // R4 latch without enable; R9 writes ignored while idle
    ime_i = 1'b0;
    wr(8'h00);
    irq_en_i = 8'h0F;
    wr(8'h10);
    irq_latch_i = 8'h10;
    wr(8'h02);
    @(negedge clk);
    chk("R4 masked latch", 8'(idle_req_o), 8'h1);
    chk("R9 write ignored", 8'(mode_o), 8'h04);
    ext_int0_i = 1'b1;
    @(negedge clk);
    chk("R4 ext wake", 8'(mode_o), 8'h00);
    chk("R6 no dispatch", 8'(int_dispatch_o), 8'h0);
    ext_int0_i = 1'b0;
    irq_latch_i = '0;
    irq_en_i = '1;
    @(negedge clk);

    // R11 wake pending at entry
    irq_latch_i = 8'h80;
    wr(8'h10);
    chk("R11 entered", 8'(idle_req_o), 8'h1);
    @(negedge clk);
    chk("R11 immediate exit", 8'(idle_req_o), 8'h0);
    irq_latch_i = '0;
    @(negedge clk);

    // R10 reset during idle
    wr(8'h02);
    wr(8'h10);
    chk("R10 in sleep", 8'(mode_o), 8'h06);
    #2 rst_ni = 1'b0;
    #1;
    chk("R10 async mode", 8'(mode_o), 8'h01);
    chk("R10 async idle", 8'(idle_req_o), 8'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 cpu runs", 8'(cpu_clk_en_o), 8'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule